// File: doc/BRIEF.md
# Bitstream Locator Memory Scanner

This block walks a fixed window of a byte-addressed memory and builds a small table of where configuration bitstreams begin. A bitstream is recognised by three marker stages: a leading marker byte, then (at some later byte) a control byte of a chosen value, then (later still) a closing marker byte. The address of each leading marker is written into a pointer table. When the closing marker has been seen, the search for the next leading marker resumes at the following byte.

The scanner drives a synchronous read port with one cycle of latency. It issues one address per cycle and compares each returned byte one cycle later, so a full window costs about one cycle per byte. A pulse on `start` clears the result and begins a scan. `busy` stays high while the scan runs, and `done` is raised when it ends. Software or a loader then reads the table through an index port, together with the count of entries found and two end-condition flags.

Top module: `bitstream_locator`

## Requirements
- R1: A `start` pulse while idle clears `count`, `full`, `truncated` and `done`, and raises `busy` at the next edge. The scanner then issues `mem_rd` with addresses 0x0400, 0x0401, … in order, one per cycle. Read data is taken to be valid on `mem_data` during the cycle after the address was issued.
- R2: While hunting, a byte equal to 0xB2 is a leading marker. Its own address is written as the next table entry and `count` increments.
- R3: After a leading marker, bytes are skipped until one equals the control value (parameter, default 0x00). Leading markers seen in this window are not recorded.
- R4: After the control byte, bytes are skipped until one equals 0x4D. Hunting then resumes with the next byte. A leading marker inside this window is not recorded, and a 0x4D seen while hunting has no effect.
- R5: Addresses below 0x0400 are never read. The last address examined is 0x0FFF, and the scan ends after that byte is compared.
- R6: When the 8th entry is recorded, the scan ends at once and `full` is set. No later bytes are compared.
- R7: If the scan reaches 0x0FFF while a bitstream is still open (after its leading marker, before its closing marker), `truncated` is set and the entry already recorded is kept. A closing marker at 0x0FFF leaves `truncated` clear.
- R8: `tbl_ptr` returns table entry `tbl_idx` without delay. Entries 0 to `count`-1 hold the recorded addresses in ascending order.
- R9: `start` while `busy` is ignored. `done` stays high until the next accepted `start`.
- R10: `busy` and `done` are never both high. `busy` falls, and `done` rises, at the edge on which the data of the last examined address is compared: two edges after that address was issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| start | input | 1 | Begin a new scan (ignored while busy) |
| mem_rd | output | 1 | Read strobe to memory |
| mem_addr | output | 16 | Read address |
| mem_data | input | 8 | Read data, one cycle after the address |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Scan finished, results valid |
| tbl_idx | input | 3 | Table entry select |
| tbl_ptr | output | 16 | Selected table entry |
| count | output | 4 | Number of entries recorded |
| full | output | 1 | Scan stopped because the table filled |
| truncated | output | 1 | Ceiling reached inside a bitstream |

## Verification
The bench aims at the boundaries of the address window. These include a marker just below the start address, a bitstream left open at the top address, a lone leading marker on the very last byte, and a closing marker that lands exactly on it. A design off by one at either end would record a stray entry or get the truncation flag wrong. Markers are placed inside the control and closing windows, and a bitstream follows another immediately, so a design that resumed hunting too early or one byte late would record extra entries or miss one. A nine-bitstream image checks that the scan stops on the eighth entry with the exact cycle count. A `start` pulse issued mid-scan would restart the scan and shift `done` if the design failed to ignore it.

// File: rtl/bsl_pkg.sv
package bsl_pkg;
   typedef enum logic [1:0] {
      ST_HUNT = 2'd0,
      ST_CTRL = 2'd1,
      ST_POST = 2'd2
   } stage_e;
endpackage

// File: rtl/bsl_fetch.sv
// Address issue stage: one read per cycle, response tracked one cycle later.
module bsl_fetch #(
   parameter int            AW         = 16,
   parameter logic [AW-1:0] START_ADDR = 16'h0400,
   parameter logic [AW-1:0] LAST_ADDR  = 16'h0FFF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic          halt,
   output logic          rd,
   output logic [AW-1:0] addr,
   output logic          rsp_vld,
   output logic [AW-1:0] rsp_addr,
   output logic          rsp_last
);
   logic live;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live     <= 1'b0;
         addr     <= '0;
         rsp_vld  <= 1'b0;
         rsp_addr <= '0;
      end else if (go) begin
         live    <= 1'b1;
         addr    <= START_ADDR;
         rsp_vld <= 1'b0;
      end else if (halt) begin
         live    <= 1'b0;
         rsp_vld <= 1'b0;
      end else begin
         rsp_vld  <= live;
         rsp_addr <= addr;
         if (live) begin
            addr <= addr + 1'b1;
            if (addr == LAST_ADDR) live <= 1'b0;
         end
      end
   end

   assign rd       = live;
   assign rsp_last = (rsp_addr == LAST_ADDR);
endmodule

// File: rtl/bsl_matcher.sv
// Three-stage marker recogniser working on returned bytes.
module bsl_matcher
   import bsl_pkg::*;
#(
   parameter int            DW        = 8,
   parameter logic [DW-1:0] PRE_BYTE  = 8'hB2,
   parameter logic [DW-1:0] CTRL_BYTE = 8'h00,
   parameter logic [DW-1:0] POST_BYTE = 8'h4D
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          vld,
   input  logic [DW-1:0] data,
   output logic          hit,
   output logic          open_after
);
   stage_e stage, stage_nxt;

   always_comb begin
      stage_nxt = stage;
      hit       = 1'b0;
      if (vld) begin
         unique case (stage)
            ST_HUNT: if (data == PRE_BYTE) begin
               hit       = 1'b1;
               stage_nxt = ST_CTRL;
            end
            ST_CTRL: if (data == CTRL_BYTE) stage_nxt = ST_POST;
            ST_POST: if (data == POST_BYTE) stage_nxt = ST_HUNT;
            default: stage_nxt = ST_HUNT;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear) stage <= ST_HUNT;
      else                 stage <= stage_nxt;
   end

   assign open_after = (stage_nxt != ST_HUNT);
endmodule

// File: rtl/bsl_ptr_table.sv
// Pointer table: one register per entry, decoded write, muxed read.
module bsl_ptr_table #(
   parameter int DEPTH = 8,
   parameter int AW    = 16,
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [IW-1:0] wr_idx,
   input  logic [AW-1:0] wr_ptr,
   input  logic [IW-1:0] rd_idx,
   output logic [AW-1:0] rd_ptr
);
   logic [AW-1:0] ent [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n)                            ent[g] <= '0;
         else if (wr && (wr_idx == IW'(g)))     ent[g] <= wr_ptr;
      end
   end

   assign rd_ptr = ent[rd_idx];
endmodule

// File: rtl/bitstream_locator.sv
module bitstream_locator #(
   parameter int AW                = 16,
   parameter int DW                = 8,
   parameter int DEPTH             = 8,
   parameter logic [AW-1:0] START_ADDR = 16'h0400,
   parameter logic [AW-1:0] END_ADDR   = 16'h1000,
   parameter logic [DW-1:0] PRE_BYTE   = 8'hB2,
   parameter logic [DW-1:0] CTRL_BYTE  = 8'h00,
   parameter logic [DW-1:0] POST_BYTE  = 8'h4D,
   localparam int IW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          mem_rd,
   output logic [AW-1:0] mem_addr,
   input  logic [DW-1:0] mem_data,
   output logic          busy,
   output logic          done,
   input  logic [IW-1:0] tbl_idx,
   output logic [AW-1:0] tbl_ptr,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          truncated
);
   localparam logic [AW-1:0] LAST_ADDR = END_ADDR - 1'b1;
   localparam logic [CW-1:0] CNT_LAST  = CW'(DEPTH - 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("bitstream_locator: DEPTH must be at least 2");
   end
   if (START_ADDR >= END_ADDR) begin : g_bad_window
      $error("bitstream_locator: START_ADDR must lie below END_ADDR");
   end

   logic          go, halt, stop_full, stop_end;
   logic          rsp_vld, rsp_last, hit, open_after;
   logic [AW-1:0] rsp_addr;

   assign go        = start && !busy;
   assign stop_full = hit && (count == CNT_LAST);
   assign stop_end  = rsp_vld && rsp_last && !stop_full;
   assign halt      = stop_full || stop_end;

   bsl_fetch #(.AW(AW), .START_ADDR(START_ADDR), .LAST_ADDR(LAST_ADDR)) u_fetch (
      .clk(clk), .rst_n(rst_n), .go(go), .halt(halt),
      .rd(mem_rd), .addr(mem_addr),
      .rsp_vld(rsp_vld), .rsp_addr(rsp_addr), .rsp_last(rsp_last)
   );

   bsl_matcher #(.DW(DW), .PRE_BYTE(PRE_BYTE), .CTRL_BYTE(CTRL_BYTE),
                 .POST_BYTE(POST_BYTE)) u_match (
      .clk(clk), .rst_n(rst_n), .clear(go), .vld(rsp_vld), .data(mem_data),
      .hit(hit), .open_after(open_after)
   );

   bsl_ptr_table #(.DEPTH(DEPTH), .AW(AW)) u_tbl (
      .clk(clk), .rst_n(rst_n), .wr(hit), .wr_idx(count[IW-1:0]),
      .wr_ptr(rsp_addr), .rd_idx(tbl_idx), .rd_ptr(tbl_ptr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         done      <= 1'b0;
         count     <= '0;
         full      <= 1'b0;
         truncated <= 1'b0;
      end else if (go) begin
         busy      <= 1'b1;
         done      <= 1'b0;
         count     <= '0;
         full      <= 1'b0;
         truncated <= 1'b0;
      end else if (busy) begin
         if (hit)       count     <= count + 1'b1;
         if (stop_full) full      <= 1'b1;
         if (stop_end)  truncated <= open_after;
         if (halt) begin
            busy <= 1'b0;
            done <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/bsl_checker.sv
module bsl_checker #(
   parameter int AW    = 16,
   parameter int CW    = 4,
   parameter int DEPTH = 8,
   parameter logic [AW-1:0] START_ADDR = 16'h0400,
   parameter logic [AW-1:0] END_ADDR   = 16'h1000
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          mem_rd,
   input logic [AW-1:0] mem_addr,
   input logic          busy,
   input logic          done,
   input logic [CW-1:0] count,
   input logic          full,
   input logic          truncated
);
   a_r10_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

   a_r5_addr_window: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> (mem_addr >= START_ADDR) && (mem_addr < END_ADDR));

   a_r1_first_addr: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_rd) |-> mem_addr == START_ADDR);

   a_r1_ascending: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd && $past(mem_rd) |-> mem_addr == AW'($past(mem_addr) + 1'b1));

   a_r6_full_count: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> count == CW'(DEPTH));

   a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));

   a_r2_count_monotone: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) |-> count >= $past(count));

   a_r9_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
      done && !start |=> done);

   a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && truncated));
endmodule

bind bitstream_locator bsl_checker #(
   .AW(AW), .CW(CW), .DEPTH(DEPTH), .START_ADDR(START_ADDR), .END_ADDR(END_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .mem_rd(mem_rd), .mem_addr(mem_addr),
   .busy(busy), .done(done), .count(count), .full(full), .truncated(truncated)
);

// File: tb/sim_bitstream_locator.sv
`timescale 1ns/1ps
module sim_bitstream_locator;
   localparam int START = 'h0400;
   localparam int STOP  = 'h1000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        mem_rd;
   logic [15:0] mem_addr;
   logic [7:0]  mem_data = 8'h00;
   logic        busy, done, full, truncated;
   logic [2:0]  tbl_idx = 3'd0;
   logic [15:0] tbl_ptr;
   logic [3:0]  count;

   logic [7:0]  mem [4096];

   int checks = 0;
   int errors = 0;

   int exp_q[$];
   bit exp_full, exp_trunc;
   int exp_last;

   always #5 clk = ~clk;

   always_ff @(posedge clk) if (mem_rd) mem_data <= mem[mem_addr[11:0]];

   bitstream_locator u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .mem_rd(mem_rd),
      .mem_addr(mem_addr), .mem_data(mem_data), .busy(busy), .done(done),
      .tbl_idx(tbl_idx), .tbl_ptr(tbl_ptr), .count(count), .full(full),
      .truncated(truncated)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h @%0t", req, act, exp, $time);
      end
   endtask

   task automatic fill(input byte v);
      for (int i = 0; i < 4096; i++) mem[i] = v;
   endtask

   // Behavioural model of the whole scan over the current memory image.
   task automatic model();
      int stage = 0;
      exp_q.delete();
      exp_full = 0;
      exp_last = STOP - 1 - START;
      for (int a = START; a < STOP; a++) begin
         if (stage == 0 && mem[a] == 8'hB2) begin
            exp_q.push_back(a);
            stage = 1;
            if (exp_q.size() == 8) begin
               exp_full = 1;
               exp_last = a - START;
               break;
            end
         end else if (stage == 1 && mem[a] == 8'h00) stage = 2;
         else if (stage == 2 && mem[a] == 8'h4D) stage = 0;
      end
      exp_trunc = !exp_full && (stage != 0);
   endtask

   // Runs one scan; busy/done compared every clock. mid >= 0 pulses start while busy.
   task automatic run_scan(input string name, input int mid);
      model();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      for (int j = 0; j <= exp_last + 2; j++) begin
         chk(busy == (j <= exp_last + 1), "R10 busy timing", busy, (j <= exp_last + 1));
         chk(done == (j >= exp_last + 2), "R10 done timing", done, (j >= exp_last + 2));
         start = (j == mid);
         @(negedge clk);
         start = 1'b0;
      end
      chk(count == exp_q.size(), {"R2 count ", name}, count, exp_q.size());
      chk(full == exp_full, {"R6 full ", name}, full, exp_full);
      chk(truncated == exp_trunc, {"R7 truncated ", name}, truncated, exp_trunc);
      foreach (exp_q[k]) begin
         tbl_idx = 3'(k);
         #1;
         chk(tbl_ptr == 16'(exp_q[k]), {"R8 entry ", name}, tbl_ptr, exp_q[k]);
      end
      repeat (3) @(negedge clk);
      chk(done == 1'b1 && busy == 1'b0, "R9 done held", done, 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      fill(8'h11);
      repeat (4) @(negedge clk);
      chk(busy == 0 && done == 0 && mem_rd == 0, "R1 reset idle", {busy, done, mem_rd}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(count == 0 && full == 0 && truncated == 0, "R1 reset flags", count, 0);

      // R5: empty window, full-length scan
      run_scan("empty", -1);

      // R3 R4: markers inside the control and closing windows, back-to-back streams
      fill(8'h11);
      mem['h03FF] = 8'hB2;                       // below window (R5)
      mem['h0400] = 8'hB2; mem['h0401] = 8'h05; mem['h0402] = 8'hB2;
      mem['h0403] = 8'h00; mem['h0404] = 8'h33; mem['h0405] = 8'hB2;
      mem['h0406] = 8'h4D;
      mem['h0407] = 8'hB2; mem['h0408] = 8'h00; mem['h0409] = 8'h4D;
      mem['h0500] = 8'h4D;                       // stray closing marker (R4)
      mem['h0800] = 8'hB2; mem['h0801] = 8'h00; mem['h0810] = 8'h4D;
      run_scan("nested", -1);
      chk(exp_q.size() == 3, "R3 model entries", exp_q.size(), 3);

      // R6 R9: nine streams, early stop, start pulse while busy ignored
      fill(8'h11);
      for (int s = 0; s < 9; s++) begin
         mem[START + s * 'h100]     = 8'hB2;
         mem[START + s * 'h100 + 1] = 8'h00;
         mem[START + s * 'h100 + 2] = 8'h4D;
      end
      run_scan("full", 100);

      // R7: stream left open at the ceiling
      fill(8'h11);
      mem['h0FF0] = 8'hB2; mem['h0FF1] = 8'h00;
      run_scan("open", -1);

      // R7 R5: lone marker on the last byte, after a complete stream
      fill(8'h11);
      mem['h0600] = 8'hB2; mem['h0601] = 8'h00; mem['h0602] = 8'h4D;
      mem['h0FFF] = 8'hB2;
      run_scan("lastbyte", -1);

      // R7 R1: closing marker exactly at the ceiling; flags cleared by new start
      fill(8'h11);
      mem['h0FFC] = 8'hB2; mem['h0FFD] = 8'h00; mem['h0FFF] = 8'h4D;
      run_scan("closed", -1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule